// File: doc/BRIEF.md
# Redundant Cell State Selector

This block serves one phase leg of a cascaded H-bridge converter built from `N_CELLS` identical cells. Each cell can drive plus one cell voltage, zero, or minus one cell voltage, so the phase can reach `2*N_CELLS+1` distinct levels. Most levels can be built from many different sets of cells. On a start pulse the selector captures a signed level request, the polarity of the phase current, the measured capacitor voltage of each cell and a bypass mask. It then decides which cells conduct so that the leg reaches the requested level, and it picks them so that the capacitor voltages move toward each other.

Whether the conducting cells gain or lose charge depends on the product of the level sign and the current sign. When that product is positive, the cells with the least stored voltage are used. When it is negative, the cells with the most stored voltage are used. The ranking runs one cell per clock through a bank of parallel comparators. A one-cycle done strobe then publishes the new per-cell code vector, and the vector holds until the next strobe. Cells in the bypass mask are left out of the ranking and always receive the zero code.

Top module: `cell_state_sel`

## Requirements
- R1: Each cell code is 2 bits at `state_o[2k+1:2k]` for cell k: 2'b00 is zero, 2'b01 is plus, 2'b10 is minus. All non-zero codes carry the sign of the captured target. The number of non-zero cells equals the smaller of |target| and the number of cells not bypassed.
- R2: When target > 0 with `cur_pos`=1, or target < 0 with `cur_pos`=0 (the cells charge), the non-zero cells are those with the lowest captured voltages.
- R3: When target > 0 with `cur_pos`=0, or target < 0 with `cur_pos`=1 (the cells discharge), the non-zero cells are those with the highest captured voltages.
- R4: Between cells of equal voltage, the cell with the lower index is chosen first.
- R5: A cell whose `bypass` bit was set at capture receives code 2'b00 and takes no place in the ranking.
- R6: `done_o` rises N_CELLS+1 clock cycles after the edge that samples `start` and stays high for exactly one cycle.
- R7: `state_o` changes only on the edge that raises `done_o` and holds its value at all other times.
- R8: A `start` pulse that arrives while a selection is in progress is ignored. It does not alter the result or the timing of the selection in progress.
- R9: A target of 0 yields code 2'b00 in every cell.
- R10: During and right after reset, `state_o` is all zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the inputs and begin a selection |
| target_lvl | input | LW | Signed requested phase level, from -N_CELLS to +N_CELLS |
| cur_pos | input | 1 | Phase current polarity, 1 = positive |
| cap_v | input | N_CELLS*VW | Unsigned capacitor voltage of each cell, cell k at bits [k*VW +: VW] |
| bypass | input | N_CELLS | Per-cell bypass mask, 1 = removed |
| state_o | output | 2*N_CELLS | Per-cell output code |
| done_o | output | 1 | One-cycle strobe that marks a new `state_o` |

## Verification
Random voltage sets are drawn from a narrow window, so ties are frequent. These sets are run with all four sign combinations of target and current, which separates the charging order from the discharging order and exposes a reversed or missing tie rule. Directed cases cover a zero target, full-magnitude targets of both signs, all-equal voltages, and bypass masks that leave fewer eligible cells than the request asks for. Further directed cases cover a second start pulse during a selection and a hold period with changing inputs, which separate the acceptance logic and the output register from the ranking itself.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        CELL_ZERO = 2'b00,
        CELL_POS  = 2'b01,
        CELL_NEG  = 2'b10
    } cell_code_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RANK,
        SEQ_EMIT
    } seq_state_e;

    typedef struct packed {
        logic charge;
        logic neg;
    } drive_mode_t;

endpackage

// File: rtl/csel_rank_unit.sv
module csel_rank_unit #(
    parameter  int N_CELLS = 5,
    parameter  int VW      = 12,
    localparam int RW      = $clog2(N_CELLS + 1),
    localparam int IW      = $clog2(N_CELLS)
) (
    input  logic [N_CELLS*VW-1:0] cap_v,
    input  logic [N_CELLS-1:0]    elig,
    input  logic                  charge,
    input  logic [IW-1:0]         idx,
    output logic [RW-1:0]         rank
);

    logic [VW-1:0]      v_self;
    logic [N_CELLS-1:0] ahead;

    always_comb begin
        v_self = '0;
        for (int k = 0; k < N_CELLS; k++) begin
            if (idx == IW'(k)) v_self = cap_v[k*VW +: VW];
        end
    end

    for (genvar j = 0; j < N_CELLS; j++) begin : g_cmp
        logic [VW-1:0] v_j;
        logic          lower_idx;
        logic          better;
        assign v_j       = cap_v[j*VW +: VW];
        assign lower_idx = IW'(j) < idx;
        assign better    = charge ? (v_j < v_self) : (v_j > v_self);
        assign ahead[j]  = elig[j] && (IW'(j) != idx) &&
                           (better || ((v_j == v_self) && lower_idx));
    end

    always_comb begin
        rank = '0;
        for (int j = 0; j < N_CELLS; j++) begin
            rank = rank + RW'(ahead[j]);
        end
    end

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl import csel_pkg::*; #(
    parameter  int N_CELLS = 5,
    localparam int IW      = $clog2(N_CELLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          rank_we,
    output logic [IW-1:0] idx,
    output logic          emit
);

    seq_state_e st_q;

    assign load    = (st_q == SEQ_IDLE) && start;
    assign rank_we = (st_q == SEQ_RANK);
    assign emit    = (st_q == SEQ_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_IDLE;
            idx  <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    idx <= '0;
                    if (start) st_q <= SEQ_RANK;
                end
                SEQ_RANK: begin
                    if (idx == IW'(N_CELLS - 1)) begin
                        st_q <= SEQ_EMIT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SEQ_EMIT: st_q <= SEQ_IDLE;
                default:  st_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cell_state_sel.sv
module cell_state_sel import csel_pkg::*; #(
    parameter  int N_CELLS = 5,
    parameter  int VW      = 12,
    localparam int RW      = $clog2(N_CELLS + 1),
    localparam int LW      = RW + 1,
    localparam int IW      = $clog2(N_CELLS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [LW-1:0]         target_lvl,
    input  logic                  cur_pos,
    input  logic [N_CELLS*VW-1:0] cap_v,
    input  logic [N_CELLS-1:0]    bypass,
    output logic [2*N_CELLS-1:0]  state_o,
    output logic                  done_o
);

    logic                  load;
    logic                  rank_we;
    logic                  emit;
    logic [IW-1:0]         idx;
    logic [RW-1:0]         rank_w;

    logic [N_CELLS*VW-1:0] volt_q;
    logic [N_CELLS-1:0]    elig_q;
    logic [RW-1:0]         mag_q;
    drive_mode_t           mode_q;
    logic [RW-1:0]         rank_q [N_CELLS];

    logic                  tgt_neg;
    logic                  tgt_pos;
    logic [LW-1:0]         tgt_abs;
    logic [RW-1:0]         tgt_mag;
    logic [2*N_CELLS-1:0]  code_next;

    assign tgt_neg = target_lvl[LW-1];
    assign tgt_pos = !tgt_neg && (target_lvl != '0);
    assign tgt_abs = tgt_neg ? (~target_lvl + 1'b1) : target_lvl;
    assign tgt_mag = (int'(tgt_abs) > N_CELLS) ? RW'(N_CELLS) : tgt_abs[RW-1:0];

    csel_ctrl #(.N_CELLS(N_CELLS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .rank_we (rank_we),
        .idx     (idx),
        .emit    (emit)
    );

    csel_rank_unit #(.N_CELLS(N_CELLS), .VW(VW)) u_rank (
        .cap_v  (volt_q),
        .elig   (elig_q),
        .charge (mode_q.charge),
        .idx    (idx),
        .rank   (rank_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            volt_q <= '0;
            elig_q <= '0;
            mag_q  <= '0;
            mode_q <= '0;
        end else if (load) begin
            volt_q        <= cap_v;
            elig_q        <= ~bypass;
            mag_q         <= tgt_mag;
            mode_q.neg    <= tgt_neg;
            mode_q.charge <= (tgt_pos && cur_pos) || (tgt_neg && !cur_pos);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_CELLS; k++) rank_q[k] <= '0;
        end else if (rank_we) begin
            rank_q[idx] <= rank_w;
        end
    end

    for (genvar k = 0; k < N_CELLS; k++) begin : g_code
        logic       active;
        cell_code_e code;
        assign active = elig_q[k] && (rank_q[k] < mag_q);
        assign code   = active ? (mode_q.neg ? CELL_NEG : CELL_POS) : CELL_ZERO;
        assign code_next[2*k +: 2] = code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= emit;
            if (emit) state_o <= code_next;
        end
    end

endmodule

// File: rtl/cell_state_sel_chk.sv
module cell_state_sel_chk #(
    parameter  int N_CELLS = 5,
    localparam int RW      = $clog2(N_CELLS + 1),
    localparam int LW      = RW + 1,
    localparam int CW      = $clog2(N_CELLS + 3)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [LW-1:0]        target_lvl,
    input logic [N_CELLS-1:0]   bypass,
    input logic [2*N_CELLS-1:0] state_o,
    input logic                 done_o
);

    logic               pending;
    logic               past_ok;
    logic [CW-1:0]      cnt;
    logic [N_CELLS-1:0] byp_q;
    logic [LW-1:0]      tgt_q;
    logic [N_CELLS-1:0] pos_m;
    logic [N_CELLS-1:0] neg_m;
    logic               accept;
    int                 want_nz;
    int                 t_int;
    int                 free_cnt;

    assign accept = start && (!pending || done_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            past_ok <= 1'b0;
            cnt     <= '0;
            byp_q   <= '0;
            tgt_q   <= '0;
        end else begin
            past_ok <= 1'b1;
            if (accept) begin
                pending <= 1'b1;
                cnt     <= '0;
                byp_q   <= bypass;
                tgt_q   <= target_lvl;
            end else if (done_o) begin
                pending <= 1'b0;
            end else if (pending) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < N_CELLS; k++) begin
            pos_m[k] = state_o[2*k +: 2] == 2'b01;
            neg_m[k] = state_o[2*k +: 2] == 2'b10;
        end
        t_int    = int'($signed(tgt_q));
        free_cnt = N_CELLS - $countones(byp_q);
        want_nz  = (t_int < 0) ? -t_int : t_int;
        if (want_nz > free_cnt) want_nz = free_cnt;
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pending && (int'(cnt) == N_CELLS + 1)));

    // R6
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        pending |-> (int'(cnt) <= N_CELLS + 1));

    // R5
    bypass_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (((pos_m | neg_m) & byp_q) == '0));

    // R1
    sign_match_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (tgt_q[LW-1] ? (pos_m == '0) : (neg_m == '0)));

    // R1
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones(pos_m | neg_m) == want_nz));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !done_o) |-> $stable(state_o));

endmodule

bind cell_state_sel cell_state_sel_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .target_lvl (target_lvl),
    .bypass     (bypass),
    .state_o    (state_o),
    .done_o     (done_o)
);

// File: tb/tb_cell_state_sel.sv
`timescale 1ns/1ps
module tb_cell_state_sel;

    localparam int N  = 5;
    localparam int VW = 12;
    localparam int RW = $clog2(N + 1);
    localparam int LW = RW + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LW-1:0]     target_lvl = '0;
    logic              cur_pos = 1'b0;
    logic [N*VW-1:0]   cap_v = '0;
    logic [N-1:0]      bypass = '0;
    logic [2*N-1:0]    state_o;
    logic              done_o;

    int n_cmp  = 0;
    int n_miss = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cell_state_sel #(.N_CELLS(N), .VW(VW)) dut (
        .clk(clk), .rst(rst), .start(start), .target_lvl(target_lvl),
        .cur_pos(cur_pos), .cap_v(cap_v), .bypass(bypass),
        .state_o(state_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Greedy reference: pick the best free cell |t| times.
    function automatic logic [2*N-1:0] ref_codes(int t, bit cp, logic [N*VW-1:0] v, logic [N-1:0] byp);
        logic [2*N-1:0] r = '0;
        bit picked [N];
        int mag = (t < 0) ? -t : t;
        bit chg = (t > 0 && cp) || (t < 0 && !cp);
        for (int k = 0; k < N; k++) picked[k] = 0;
        if (mag > N) mag = N;
        for (int p = 0; p < mag; p++) begin
            int best = -1;
            for (int j = 0; j < N; j++) begin
                if (!byp[j] && !picked[j]) begin
                    if (best < 0) best = j;
                    else if (chg ? (v[j*VW +: VW] < v[best*VW +: VW])
                                 : (v[j*VW +: VW] > v[best*VW +: VW])) best = j;
                end
            end
            if (best >= 0) begin
                picked[best] = 1;
                r[2*best +: 2] = (t < 0) ? 2'b10 : 2'b01;
            end
        end
        return r;
    endfunction

    task automatic drive_start(input int t, input bit cp, input logic [N*VW-1:0] v, input logic [N-1:0] byp);
        @(negedge clk);
        target_lvl = LW'(t);
        cur_pos    = cp;
        cap_v      = v;
        bypass     = byp;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    // After drive_start returns, one edge (E0) has passed.
    task automatic wait_done(output int lat);
        lat = 0;
        for (int k = 1; k <= N + 4; k++) begin
            if (done_o) begin
                lat = k - 1;
                break;
            end
            @(negedge clk);
        end
        if (lat == 0 && done_o) lat = N + 4;
    endtask

    task automatic run_case(input int t, input bit cp, input logic [N*VW-1:0] v,
                            input logic [N-1:0] byp, input string req);
        int lat;
        logic [2*N-1:0] exp;
        exp = ref_codes(t, cp, v, byp);
        drive_start(t, cp, v, byp);
        wait_done(lat);
        // done seen at negedge after E(lat); required lat = N+1
        check(lat == N + 1, "R6 latency", lat, N + 1);
        check(state_o == exp, req, state_o, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R6 pulse width", done_o, 0);
    endtask

    function automatic logic [N*VW-1:0] rand_volts(int span);
        logic [N*VW-1:0] v;
        for (int k = 0; k < N; k++) v[k*VW +: VW] = VW'(1000 + $urandom_range(0, span));
        return v;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++;
            n_miss++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

    initial begin
        logic [N*VW-1:0] v;
        logic [2*N-1:0] held;
        int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(state_o == '0, "R10 state", state_o, 0);
        check(done_o == 1'b0, "R10 done", done_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(state_o == '0 && !done_o, "R10 after reset", {done_o, state_o}, 0);

        // Distinct voltages: cell k voltage values
        v = {12'd900, 12'd1300, 12'd1100, 12'd1000, 12'd1200};
        // R2 charging +2: lowest two are cell1(1000), cell0(1200)? lowest: 900(c4),1000(c1)
        run_case(2, 1, v, '0, "R2 charge positive");
        check(state_o == 10'b01_00_00_01_00, "R2 explicit", state_o, 10'b01_00_00_01_00);
        // R3 discharging +2: highest 1300(c3),1200(c0)
        run_case(2, 0, v, '0, "R3 discharge positive");
        check(state_o == 10'b00_01_00_00_01, "R3 explicit", state_o, 10'b00_01_00_00_01);
        // R2 charging -3 (cur negative): lowest three c4,c1,c2 minus
        run_case(-3, 0, v, '0, "R2 charge negative");
        // R3 discharging -1: highest c3
        run_case(-1, 1, v, '0, "R3 discharge negative");
        check(state_o == 10'b00_10_00_00_00, "R3 explicit neg", state_o, 10'b00_10_00_00_00);
        // R9 zero target
        run_case(0, 1, v, '0, "R9 zero target");
        check(state_o == '0, "R9 all zero", state_o, 0);
        // R1 full magnitude both signs
        run_case(N, 1, v, '0, "R1 full positive");
        check(state_o == {N{2'b01}}, "R1 all plus", state_o, {N{2'b01}});
        run_case(-N, 1, v, '0, "R1 full negative");
        // R4 ties: all equal voltages, lower index first in both orders
        v = {N{12'd1500}};
        run_case(3, 1, v, '0, "R4 tie charge");
        check(state_o == 10'b00_00_01_01_01, "R4 tie explicit", state_o, 10'b00_00_01_01_01);
        run_case(2, 0, v, '0, "R4 tie discharge");
        check(state_o == 10'b00_00_00_01_01, "R4 tie discharge explicit", state_o, 10'b00_00_00_01_01);
        // R5 bypass: cell 0 and 2 removed, request 4 -> only 3 available
        run_case(4, 1, v, 5'b00101, "R5 bypass short");
        check(state_o == 10'b01_01_00_01_00, "R5 bypass explicit", state_o, 10'b01_01_00_01_00);
        v = {12'd900, 12'd1300, 12'd1100, 12'd1000, 12'd1200};
        run_case(-2, 0, v, 5'b10000, "R5 bypass excludes lowest");

        // R8 start while busy is ignored
        v = {12'd900, 12'd1300, 12'd1100, 12'd1000, 12'd1200};
        drive_start(1, 1, v, '0);
        start = 1'b1; target_lvl = LW'(-4); cur_pos = 1'b0; bypass = 5'b00011;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check(lat == N, "R8 timing kept", lat, N);
        check(state_o == ref_codes(1, 1, v, '0), "R8 result kept", state_o, ref_codes(1, 1, v, '0));
        for (int k = 0; k < N + 3; k++) begin
            @(negedge clk);
            check(done_o == 1'b0, "R8 no second done", done_o, 0);
        end

        // R7 hold while inputs move without start
        held = state_o;
        for (int k = 0; k < 6; k++) begin
            cap_v = rand_volts(400);
            target_lvl = LW'($urandom_range(0, 2*N) - N);
            bypass = N'($urandom);
            @(negedge clk);
            check(state_o == held && !done_o, "R7 hold", state_o, held);
        end

        // Random sweep, narrow window to force ties (R1..R5)
        for (int i = 0; i < 400; i++) begin
            int t = int'($urandom_range(0, 2*N)) - N;
            bit cp = 1'($urandom);
            logic [N-1:0] byp = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            run_case(t, cp, rand_volts((i % 2) ? 7 : 2000), byp, "R1 R2 R3 R4 R5 random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule